// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Selector

This block sits beside the execute stage of a five-stage in-order pipeline and decides where each of the two ALU operands comes from. The value read from the register file during decode is not always current. An older instruction may still hold a newer value for that register, either as an ALU result waiting in the EX/MEM register or as a final write-back value in the MEM/WB register. For each operand the block compares the source register index of the instruction in execute with the destination indices of the two older instructions. It then emits a two-bit select code that steers the operand multiplexer.

A loaded value only exists once the memory stage has finished. Bypassing therefore cannot serve an instruction that reads a register written by a load directly ahead of it. The block detects this case one stage earlier, when the load is in execute and the consumer is in decode, and raises a stall request. The surrounding pipeline uses that request to hold the PC and the IF/ID register and to insert an empty slot, with every write enable cleared, into ID/EX. One cycle later the loaded data sits in MEM/WB and the normal bypass rules deliver it. The block is purely combinational.

Top module: `fwd_unit`

## Requirements
- R1: When neither older stage writes a register matching an operand's source index, that operand's select is 2'b00 (register file value). The value 2'b11 is never produced.
- R2: When EX/MEM has its write enable set, a nonzero destination equal to the operand's source, and is not a load, the select is 2'b10 (EX/MEM result).
- R3: When MEM/WB has its write enable set and a nonzero destination equal to the operand's source, and EX/MEM does not target that same register, the select is 2'b01 (MEM/WB write-back value).
- R4: When both EX/MEM (non-load) and MEM/WB target the operand's source register, the newer EX/MEM result wins and the select is 2'b10.
- R5: Source index 0 is never bypassed: its select is 2'b00 even when both older stages write register 0 with write enable set.
- R6: A stage whose write enable is clear is ignored for bypassing, even when its destination index matches.
- R7: Operand A and operand B are evaluated independently with identical rules, so a hit on one has no effect on the other's select.
- R8: A load in EX/MEM never supplies its address result as operand data. When it targets the operand's source, the select is 2'b00 and MEM/WB is not chosen for that register either.
- R9: The stall request is high when the instruction in ID/EX is a load with a nonzero destination that equals either source index of the instruction in decode.
- R10: The stall request is low when the ID/EX instruction is not a load, when its destination is register 0, or when neither decode source matches it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_src_a | input | 5 | Operand A source register index of the instruction in execute (ID/EX) |
| ex_src_b | input | 5 | Operand B source register index of the instruction in execute (ID/EX) |
| ex_dst | input | 5 | Destination register index of the instruction in execute |
| ex_is_load | input | 1 | Instruction in execute is a load |
| mem_dst | input | 5 | Destination register index held in EX/MEM |
| mem_wr_en | input | 1 | EX/MEM instruction writes a register |
| mem_is_load | input | 1 | EX/MEM instruction is a load |
| wb_dst | input | 5 | Destination register index held in MEM/WB |
| wb_wr_en | input | 1 | MEM/WB instruction writes a register |
| dec_src_a | input | 5 | First source register index of the instruction in decode (IF/ID) |
| dec_src_b | input | 5 | Second source register index of the instruction in decode (IF/ID) |
| op_a_sel | output | 2 | Operand A source: 00 register file, 10 EX/MEM, 01 MEM/WB |
| op_b_sel | output | 2 | Operand B source: 00 register file, 10 EX/MEM, 01 MEM/WB |
| stall_req | output | 1 | Load-use hazard: hold fetch and decode and insert an empty slot |

## Verification
The bench targets chains of writes to one register from both older stages. A design without the priority rule would hand the consumer a stale MEM/WB value there. It drives register 0 as a destination with write enables set, which a careless design would bypass to produce garbage instead of the hard-wired zero. It also places a load in EX/MEM on the consumer's register. The bench expects the address never to be routed as data, and expects the older MEM/WB copy not to leak through in its place. For stall detection it sweeps non-loads, loads to register 0 and matches on each decode source separately. Any of these errors would either freeze the pipeline for no reason or let a consumer read a value that is not yet loaded.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

  typedef enum logic [1:0] {
    SEL_REGFILE = 2'b00,
    SEL_WB      = 2'b01,
    SEL_MEM     = 2'b10
  } fwd_sel_e;

  localparam int unsigned NUM_OPERANDS = 2;

endpackage

// File: rtl/fwd_operand_sel.sv
module fwd_operand_sel
  import fwd_pkg::*;
#(
  parameter int unsigned IDX_W = 5
) (
  input  logic [IDX_W-1:0] src_idx,
  input  logic [IDX_W-1:0] mem_dst,
  input  logic             mem_wr_en,
  input  logic             mem_is_load,
  input  logic [IDX_W-1:0] wb_dst,
  input  logic             wb_wr_en,
  output logic [1:0]       sel
);

  // True when a producer with the given enable and destination writes the
  // register this operand reads; register 0 is never a real producer.
  function automatic logic producer_hits(input logic we,
                                         input logic [IDX_W-1:0] dst,
                                         input logic [IDX_W-1:0] src);
    return we && (dst != '0) && (dst == src);
  endfunction

  logic     mem_hit;      // EX/MEM targets this register
  logic     mem_fwd_ok;   // EX/MEM may supply data (not a load)
  logic     wb_hit;       // MEM/WB targets this register
  logic     wb_fwd_ok;    // MEM/WB may supply data (not shadowed)
  fwd_sel_e sel_e;

  assign mem_hit    = producer_hits(mem_wr_en, mem_dst, src_idx);
  assign mem_fwd_ok = mem_hit && !mem_is_load;
  assign wb_hit     = producer_hits(wb_wr_en, wb_dst, src_idx);
  assign wb_fwd_ok  = wb_hit && !mem_hit;

  always_comb begin
    if (mem_fwd_ok)     sel_e = SEL_MEM;
    else if (wb_fwd_ok) sel_e = SEL_WB;
    else                sel_e = SEL_REGFILE;
  end

  assign sel = sel_e;

  always_comb begin
    AST_SEL_LEGAL: assert (sel != 2'b11) else $error("illegal select"); // R1
    AST_MEM_SEL_QUALIFIED: assert (sel != SEL_MEM ||
      (mem_wr_en && !mem_is_load && mem_dst != '0 && mem_dst == src_idx))
      else $error("EX/MEM select without qualifying producer"); // R2
    AST_WB_NOT_SHADOWED: assert (sel != SEL_WB ||
      !(mem_wr_en && mem_dst != '0 && mem_dst == src_idx))
      else $error("MEM/WB chosen while EX/MEM holds newer value"); // R4
    AST_ZERO_NEVER_FWD: assert (src_idx != '0 || sel == SEL_REGFILE)
      else $error("register 0 bypassed"); // R5
    AST_LOAD_NO_DATA: assert (!(mem_is_load && mem_wr_en && mem_dst == src_idx)
      || sel == SEL_REGFILE)
      else $error("load in EX/MEM bypassed"); // R8
  end

endmodule

// File: rtl/fwd_load_use_det.sv
module fwd_load_use_det #(
  parameter int unsigned IDX_W   = 5,
  parameter int unsigned NUM_SRC = 2
) (
  input  logic                     ex_is_load,
  input  logic [IDX_W-1:0]         ex_dst,
  input  logic [NUM_SRC*IDX_W-1:0] dec_srcs,
  output logic                     stall
);

  logic [NUM_SRC-1:0] src_match;   // per decode source: reads the load target
  logic               load_live;   // load with a real destination in execute

  generate
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      assign src_match[i] = (dec_srcs[i*IDX_W +: IDX_W] == ex_dst);
    end
  endgenerate

  assign load_live = ex_is_load && (ex_dst != '0);
  assign stall     = load_live && (|src_match);

  always_comb begin
    AST_STALL_NEEDS_LOAD: assert (!stall || ex_is_load)
      else $error("stall without load"); // R9
    AST_STALL_NONZERO_DST: assert (!stall || ex_dst != '0)
      else $error("stall on register 0"); // R10
    AST_STALL_NEEDS_MATCH: assert (!stall ||
      dec_srcs[IDX_W-1:0] == ex_dst || dec_srcs[2*IDX_W-1:IDX_W] == ex_dst)
      else $error("stall without source match"); // R10
  end

endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
  import fwd_pkg::*;
#(
  parameter int unsigned IDX_W = 5
) (
  input  logic [IDX_W-1:0] ex_src_a,
  input  logic [IDX_W-1:0] ex_src_b,
  input  logic [IDX_W-1:0] ex_dst,
  input  logic             ex_is_load,
  input  logic [IDX_W-1:0] mem_dst,
  input  logic             mem_wr_en,
  input  logic             mem_is_load,
  input  logic [IDX_W-1:0] wb_dst,
  input  logic             wb_wr_en,
  input  logic [IDX_W-1:0] dec_src_a,
  input  logic [IDX_W-1:0] dec_src_b,
  output logic [1:0]       op_a_sel,
  output logic [1:0]       op_b_sel,
  output logic             stall_req
);

  localparam int unsigned SRC_BUS_W = NUM_OPERANDS * IDX_W;

  logic [SRC_BUS_W-1:0]    ex_srcs;
  logic [SRC_BUS_W-1:0]    dec_srcs;
  logic [2*NUM_OPERANDS-1:0] sel_bus;

  assign ex_srcs  = {ex_src_b, ex_src_a};
  assign dec_srcs = {dec_src_b, dec_src_a};

  generate
    for (genvar op = 0; op < NUM_OPERANDS; op++) begin : g_op
      fwd_operand_sel #(.IDX_W(IDX_W)) u_sel (
        .src_idx    (ex_srcs[op*IDX_W +: IDX_W]),
        .mem_dst    (mem_dst),
        .mem_wr_en  (mem_wr_en),
        .mem_is_load(mem_is_load),
        .wb_dst     (wb_dst),
        .wb_wr_en   (wb_wr_en),
        .sel        (sel_bus[op*2 +: 2])
      );
    end
  endgenerate

  fwd_load_use_det #(.IDX_W(IDX_W), .NUM_SRC(NUM_OPERANDS)) u_lu (
    .ex_is_load(ex_is_load),
    .ex_dst    (ex_dst),
    .dec_srcs  (dec_srcs),
    .stall     (stall_req)
  );

  assign op_a_sel = sel_bus[1:0];
  assign op_b_sel = sel_bus[3:2];

  always_comb begin
    AST_OPS_INDEPENDENT: assert (ex_src_a != ex_src_b || op_a_sel == op_b_sel)
      else $error("same source, different selects"); // R7
  end

endmodule

// File: tb/fwd_unit_tb.sv
module fwd_unit_tb;

  localparam int CLK_PERIOD = 10;
  localparam int W = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [W-1:0] ex_src_a, ex_src_b, ex_dst, mem_dst, wb_dst, dec_src_a, dec_src_b;
  logic ex_is_load, mem_wr_en, mem_is_load, wb_wr_en;
  logic [1:0] op_a_sel, op_b_sel;
  logic stall_req;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  fwd_unit #(.IDX_W(W)) u_dut (
    .ex_src_a(ex_src_a), .ex_src_b(ex_src_b), .ex_dst(ex_dst),
    .ex_is_load(ex_is_load), .mem_dst(mem_dst), .mem_wr_en(mem_wr_en),
    .mem_is_load(mem_is_load), .wb_dst(wb_dst), .wb_wr_en(wb_wr_en),
    .dec_src_a(dec_src_a), .dec_src_b(dec_src_b),
    .op_a_sel(op_a_sel), .op_b_sel(op_b_sel), .stall_req(stall_req)
  );

  // Reference: newest writer of the register decides; a load there blocks all.
  function automatic logic [1:0] ref_sel(input logic [W-1:0] s);
    if (s == 0) return 2'b00;
    if (mem_wr_en && mem_dst == s) return mem_is_load ? 2'b00 : 2'b10;
    if (wb_wr_en && wb_dst == s) return 2'b01;
    return 2'b00;
  endfunction

  function automatic logic ref_stall();
    if (!ex_is_load || ex_dst == 0) return 1'b0;
    return (dec_src_a == ex_dst) || (dec_src_b == ex_dst);
  endfunction

  function automatic string sel_tag(input logic [1:0] e);
    return (e == 2'b10) ? "R2" : (e == 2'b01) ? "R3" : "R1";
  endfunction

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [W-1:0] sa, sb, ed, input logic el,
                       input logic [W-1:0] md, input logic mw, ml,
                       input logic [W-1:0] wd, input logic ww,
                       input logic [W-1:0] da, db);
    @(negedge clk);
    ex_src_a = sa; ex_src_b = sb; ex_dst = ed; ex_is_load = el;
    mem_dst = md; mem_wr_en = mw; mem_is_load = ml;
    wb_dst = wd; wb_wr_en = ww; dec_src_a = da; dec_src_b = db;
    @(posedge clk); #1;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    drive(0,0,0,0, 0,0,0, 0,0, 0,0);
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    // reset-like idle state
    chk("R1 idle a", {2'b0, op_a_sel}, 4'h0);
    chk("R1 idle b", {2'b0, op_b_sel}, 4'h0);
    chk("R10 idle stall", {3'b0, stall_req}, 4'h0);
    // R2 plain EX/MEM bypass on A only; R7 B unaffected
    drive(3,4,0,0, 3,1,0, 0,0, 0,0);
    chk("R2 mem fwd a", {2'b0, op_a_sel}, 4'h2);
    chk("R7 b untouched", {2'b0, op_b_sel}, 4'h0);
    // R3 MEM/WB bypass on B
    drive(1,6,0,0, 2,1,0, 6,1, 0,0);
    chk("R3 wb fwd b", {2'b0, op_b_sel}, 4'h1);
    chk("R7 a untouched", {2'b0, op_a_sel}, 4'h0);
    // R4 r1 written by both stages
    drive(1,1,0,0, 1,1,0, 1,1, 0,0);
    chk("R4 priority a", {2'b0, op_a_sel}, 4'h2);
    chk("R4 priority b", {2'b0, op_b_sel}, 4'h2);
    // R5 register 0
    drive(0,0,0,0, 0,1,0, 0,1, 0,0);
    chk("R5 zero a", {2'b0, op_a_sel}, 4'h0);
    chk("R5 zero b", {2'b0, op_b_sel}, 4'h0);
    // R6 write enables low
    drive(5,7,0,0, 5,0,0, 7,0, 0,0);
    chk("R6 mem we low", {2'b0, op_a_sel}, 4'h0);
    chk("R6 wb we low", {2'b0, op_b_sel}, 4'h0);
    // R6 EX/MEM disabled lets MEM/WB through
    drive(5,5,0,0, 5,0,0, 5,1, 0,0);
    chk("R6 wb through", {2'b0, op_a_sel}, 4'h1);
    // R8 load in EX/MEM, older MEM/WB copy too
    drive(4,9,0,0, 4,1,1, 4,1, 0,0);
    chk("R8 load no data", {2'b0, op_a_sel}, 4'h0);
    chk("R8 other op", {2'b0, op_b_sel}, 4'h0);
    // R9 stall on each decode source
    drive(0,0,4,1, 0,0,0, 0,0, 4,2);
    chk("R9 stall src a", {3'b0, stall_req}, 4'h1);
    drive(0,0,4,1, 0,0,0, 0,0, 2,4);
    chk("R9 stall src b", {3'b0, stall_req}, 4'h1);
    // R10 no stall cases
    drive(0,0,4,0, 0,0,0, 0,0, 4,4);
    chk("R10 not load", {3'b0, stall_req}, 4'h0);
    drive(0,0,0,1, 0,0,0, 0,0, 0,0);
    chk("R10 dst zero", {3'b0, stall_req}, 4'h0);
    drive(0,0,4,1, 0,0,0, 0,0, 3,5);
    chk("R10 no match", {3'b0, stall_req}, 4'h0);

    // Random phase on a small index range to force collisions
    void'($urandom(32'd20240917));
    for (int i = 0; i < 3000; i++) begin
      logic [1:0] ea, eb;
      drive($urandom_range(0,3), $urandom_range(0,3), $urandom_range(0,3), 1'($urandom_range(0,1)),
            $urandom_range(0,3), 1'($urandom_range(0,1)), 1'($urandom_range(0,1)),
            $urandom_range(0,3), 1'($urandom_range(0,1)),
            $urandom_range(0,3), $urandom_range(0,3));
      ea = ref_sel(ex_src_a);
      eb = ref_sel(ex_src_b);
      chk({sel_tag(ea), " rand a"}, {2'b0, op_a_sel}, {2'b0, ea});
      chk({sel_tag(eb), " rand b"}, {2'b0, op_b_sel}, {2'b0, eb});
      chk(ref_stall() ? "R9 rand stall" : "R10 rand stall", {3'b0, stall_req}, {3'b0, ref_stall()});
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule